// File: doc/BRIEF.md
# Potentiometer SPI Command Header Decoder

This block is the serial front end of a four-channel digitally controlled potentiometer. It listens to a mode-0 serial link (data sampled on the rising serial clock while the active-low select is asserted) and works out the two-byte header that opens every frame. The first byte after select goes low is a device identification byte. Its upper nibble must carry the fixed device-type code and its lower nibble must carry the slave address. Part of that address is fixed at zero and the rest is taken from two strap inputs.

When the identification byte matches, the next byte is received as a command byte. It is split into a four-bit opcode, a two-bit data-register index and a two-bit wiper (channel) index. These are presented with a single-cycle strobe in the system clock domain. All serial inputs are brought into the system clock through two-flop synchronisers, and serial clock edges are found by oversampling. Two active-low guard inputs (pause and write-protect) must stay high throughout the frame, or the frame is abandoned. The serial data output never drives the line: its enable is held low, so the input and output wires may be tied together.

Top module: `pot_cmd_hdr_dec`

## Requirements
- R1: While reset is asserted, the strobe is low, the opcode, register and wiper outputs are zero, and both the serial output data and its enable are low.
- R2: A data bit is taken only on a rising serial clock edge seen while select is low, most significant bit first. Clock edges while select is high have no effect on the next frame.
- R3: The identification byte is accepted only if its bits 7:4 equal 4'b0101.
- R4: The identification byte is accepted only if its bits 3:2 are 2'b00 and its bits 1:0 equal addr_strap_i[1:0].
- R5: After a rejected identification byte, no strobe is produced for the rest of that frame, even if later bytes form a valid header, and the field outputs keep their values.
- R6: After an accepted identification byte, the eighth bit of the next byte produces a one-cycle cmd_valid_o. In the same cycle cmd_op_o = byte[7:4], cmd_dreg_o = byte[3:2] (00..11 select data register 0..3) and cmd_wiper_o = byte[1:0]. The field outputs change only with the strobe.
- R7: If pause_ni or wrprot_ni is low at any time while select is low, the frame is abandoned with no strobe. The next frame is decoded normally.
- R8: Raising select clears the bit count and the byte state. A frame cut short mid-byte does not disturb the alignment of the next frame.
- R9: When select rises in the same synchronised cycle as the eighth rising clock edge of the command byte, no strobe is produced.
- R10: spi_miso_oe_o and spi_miso_o stay low at all times.
- R11: Bytes after the command byte in the same frame are ignored: exactly one strobe per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_clk_i | input | 1 | Serial clock, idle low |
| spi_mosi_i | input | 1 | Serial data in |
| spi_sel_ni | input | 1 | Active-low select |
| pause_ni | input | 1 | Active-low pause guard; low aborts the frame |
| wrprot_ni | input | 1 | Active-low write-protect guard; low aborts the frame |
| addr_strap_i | input | 2 | Strapped low address bits |
| spi_miso_o | output | 1 | Serial data out (constant low) |
| spi_miso_oe_o | output | 1 | Output enable for the external tri-state buffer (always low) |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded command |
| cmd_op_o | output | 4 | Opcode field |
| cmd_dreg_o | output | 2 | Data-register index |
| cmd_wiper_o | output | 2 | Wiper / channel index |

## Verification
The completion of the command byte and the end of the frame by select rising can fall in the same system clock cycle. In that case the deselect must win. The bench provokes this by raising the serial clock for the last command bit and releasing select at the same instant, so both pass through identical synchronisers and arrive together. It then checks that the strobe count does not move and the field outputs keep their earlier values. Guard drops in mid-byte are checked the same way, followed by a clean frame to show that recovery happens at the next select.

// File: rtl/pot_hdr_pkg.sv
package pot_hdr_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [1:0] {
    ST_WAIT_ID  = 2'd0,
    ST_WAIT_CMD = 2'd1,
    ST_DROP     = 2'd2
  } frm_state_e;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] dreg;
    logic [1:0] wiper;
  } cmd_fields_t;

  // Identification byte check: type nibble, fixed-zero bits, strapped bits.
  function automatic logic id_accept(input logic [BYTE_W-1:0] idb,
                                     input logic [1:0] strap);
    return (idb[7:4] == DEV_TYPE) && (idb[3:2] == 2'b00) && (idb[1:0] == strap);
  endfunction

  // Command byte split into opcode, register index and wiper index.
  function automatic cmd_fields_t split_cmd(input logic [BYTE_W-1:0] b);
    cmd_fields_t f;
    f.op    = b[7:4];
    f.dreg  = b[3:2];
    f.wiper = b[1:0];
    return f;
  endfunction

endpackage

// File: rtl/pot_hdr_sync.sv
module pot_hdr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain <= {STAGES{RST_VAL[b]}};
        else         chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pot_hdr_shift.sv
module pot_hdr_shift
  import pot_hdr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              sel_act_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);

  logic              sck_q;
  logic              sck_rise;
  logic [BYTE_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign sck_rise = sck_s_i & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_q <= sck_s_i;
      if (!sel_act_i) begin
        sr_q  <= '0;
        cnt_q <= '0;
      end else if (sck_rise) begin
        sr_q  <= {sr_q[BYTE_W-3:0], mosi_s_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign byte_done_o = sel_act_i & sck_rise & (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_o      = {sr_q, mosi_s_i};
  assign bit_cnt_o   = cnt_q;

endmodule

// File: rtl/pot_hdr_fsm.sv
module pot_hdr_fsm
  import pot_hdr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_act_i,
  input  logic              guard_ok_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [1:0]        strap_i,
  output logic              valid_o,
  output cmd_fields_t       fields_o,
  output logic              id_ok_o
);

  frm_state_e  state_q, state_d;
  cmd_fields_t fields_q;
  logic        valid_q, valid_d;

  assign id_ok_o = id_accept(byte_i, strap_i);

  always_comb begin
    state_d = state_q;
    valid_d = 1'b0;
    if (!sel_act_i) begin
      state_d = ST_WAIT_ID;
    end else if (!guard_ok_i) begin
      state_d = ST_DROP;
    end else if (byte_done_i) begin
      unique case (state_q)
        ST_WAIT_ID:  state_d = id_ok_o ? ST_WAIT_CMD : ST_DROP;
        ST_WAIT_CMD: begin
          state_d = ST_DROP;
          valid_d = 1'b1;
        end
        default:     state_d = ST_DROP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT_ID;
      valid_q  <= 1'b0;
      fields_q <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      if (valid_d) fields_q <= split_cmd(byte_i);
    end
  end

  assign valid_o  = valid_q;
  assign fields_o = fields_q;

endmodule

// File: rtl/pot_cmd_hdr_dec.sv
module pot_cmd_hdr_dec
  import pot_hdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       spi_clk_i,
  input  logic       spi_mosi_i,
  input  logic       spi_sel_ni,
  input  logic       pause_ni,
  input  logic       wrprot_ni,
  input  logic [1:0] addr_strap_i,
  output logic       spi_miso_o,
  output logic       spi_miso_oe_o,
  output logic       cmd_valid_o,
  output logic [3:0] cmd_op_o,
  output logic [1:0] cmd_dreg_o,
  output logic [1:0] cmd_wiper_o
);

  localparam int NSYNC = 7;
  // bit order: strap[1:0], wrprot, pause, sel, mosi, sck
  localparam logic [NSYNC-1:0] SYNC_RST = 7'b0011100;

  logic [NSYNC-1:0]  raw_in, syn_in;
  logic              sck_s, mosi_s, sel_act, guard_ok;
  logic [1:0]        strap_s;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [CNT_W-1:0]  bit_cnt;
  logic              id_ok;
  cmd_fields_t       fields;

  assign raw_in = {addr_strap_i, wrprot_ni, pause_ni, spi_sel_ni, spi_mosi_i, spi_clk_i};

  pot_hdr_sync #(
    .W       (NSYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (syn_in)
  );

  assign sck_s    = syn_in[0];
  assign mosi_s   = syn_in[1];
  assign sel_act  = ~syn_in[2];
  assign guard_ok = syn_in[3] & syn_in[4];
  assign strap_s  = syn_in[6:5];

  pot_hdr_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_s_i     (sck_s),
    .mosi_s_i    (mosi_s),
    .sel_act_i   (sel_act),
    .byte_done_o (byte_done),
    .byte_o      (byte_val),
    .bit_cnt_o   (bit_cnt)
  );

  pot_hdr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_act_i   (sel_act),
    .guard_ok_i  (guard_ok),
    .byte_done_i (byte_done),
    .byte_i      (byte_val),
    .strap_i     (strap_s),
    .valid_o     (cmd_valid_o),
    .fields_o    (fields),
    .id_ok_o     (id_ok)
  );

  assign cmd_op_o      = fields.op;
  assign cmd_dreg_o    = fields.dreg;
  assign cmd_wiper_o   = fields.wiper;
  assign spi_miso_o    = 1'b0;
  assign spi_miso_oe_o = 1'b0;

endmodule

// File: rtl/pot_cmd_hdr_dec_chk.sv
module pot_cmd_hdr_dec_chk
  import pot_hdr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_act_i,
  input logic             guard_ok_i,
  input logic             byte_done_i,
  input logic [CNT_W-1:0] bit_cnt_i,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [1:0]       dreg_i,
  input logic [1:0]       wiper_i
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i); // R6

  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(op_i) && $stable(dreg_i) && $stable(wiper_i))); // R6

  AST_VALID_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(sel_act_i)); // R9

  AST_VALID_NEEDS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(guard_ok_i)); // R7

  AST_DESEL_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_act_i |=> (bit_cnt_i == '0)); // R8

  AST_NO_BYTE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_act_i |-> !byte_done_i); // R2

endmodule

bind pot_cmd_hdr_dec pot_cmd_hdr_dec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_act_i   (sel_act),
  .guard_ok_i  (guard_ok),
  .byte_done_i (byte_done),
  .bit_cnt_i   (bit_cnt),
  .valid_i     (cmd_valid_o),
  .op_i        (cmd_op_o),
  .dreg_i      (cmd_dreg_o),
  .wiper_i     (cmd_wiper_o)
);

// File: tb/pot_cmd_hdr_dec_tb.sv
module pot_cmd_hdr_dec_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       sck = 1'b0, mosi = 1'b0, sel_n = 1'b1, pause_n = 1'b1, wp_n = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       miso, miso_oe, valid;
  logic [3:0] op;
  logic [1:0] dreg, wiper;

  pot_cmd_hdr_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .spi_clk_i(sck), .spi_mosi_i(mosi),
    .spi_sel_ni(sel_n), .pause_ni(pause_n), .wrprot_ni(wp_n),
    .addr_strap_i(strap), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .cmd_valid_o(valid), .cmd_op_o(op), .cmd_dreg_o(dreg), .cmd_wiper_o(wiper)
  );

  int checks = 0, errors = 0, vcnt = 0, oe_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) vcnt++;
      if (miso_oe || miso) oe_seen++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      wclk(8);
      sck = 1'b1;
      wclk(8);
      sck = 1'b0;
    end
  endtask

  task automatic sel_on();
    sel_n = 1'b0;
    wclk(8);
  endtask

  task automatic sel_off();
    wclk(8);
    sel_n = 1'b1;
    wclk(16);
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input int nbytes);
    sel_on();
    send_bits(b0, 8);
    if (nbytes > 1) send_bits(b1, 8);
    if (nbytes > 2) send_bits(b2, 8);
    sel_off();
  endtask

  task automatic expect_cmd(input int base, input logic [7:0] c, input string tag);
    chk(vcnt == base + 1, {tag, " strobe count"}, vcnt - base, 1);
    chk(op == c[7:4], {tag, " opcode"}, op, c[7:4]);
    chk(dreg == c[3:2], {tag, " dreg"}, dreg, c[3:2]);
    chk(wiper == c[1:0], {tag, " wiper"}, wiper, c[1:0]);
  endtask

  // {strap[1:0], id[7:0], cmd[7:0], accept}
  localparam logic [18:0] VECS [0:7] = '{
    {2'b00, 8'h50, 8'hA7, 1'b1},  // R6 plain accept
    {2'b11, 8'h53, 8'h3C, 1'b1},  // R4 strap 11
    {2'b10, 8'h52, 8'hF1, 1'b1},  // R4 strap 10
    {2'b01, 8'h51, 8'h00, 1'b1},  // R4 strap 01
    {2'b00, 8'h40, 8'h11, 1'b0},  // R3 wrong type nibble
    {2'b00, 8'h58, 8'h22, 1'b0},  // R4 fixed bit set
    {2'b01, 8'h50, 8'h33, 1'b0},  // R4 strap mismatch
    {2'b00, 8'hD0, 8'h44, 1'b0}   // R3 wrong type nibble
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    logic [3:0] p_op;
    logic [1:0] p_dr, p_wp;
    wclk(5);
    chk(valid == 1'b0, "R1 strobe in reset", valid, 0);
    chk({op, dreg, wiper} == 8'h00, "R1 fields in reset", {op, dreg, wiper}, 0);
    chk({miso, miso_oe} == 2'b00, "R1 miso in reset", {miso, miso_oe}, 0);
    rst_n = 1'b1;
    wclk(5);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] s;
      logic [7:0] idb, cmd;
      s = VECS[v][18:17]; idb = VECS[v][16:9]; cmd = VECS[v][8:1];
      strap = s;
      wclk(8);
      base = vcnt;
      if (VECS[v][0]) begin
        frame(idb, cmd, 8'h00, 2);
        expect_cmd(base, cmd, "R3 R4 R6 accept");
      end else begin
        p_op = op; p_dr = dreg; p_wp = wiper;
        frame(idb, {4'b0101, 2'b00, s}, cmd, 3);
        chk(vcnt == base, "R3 R4 R5 reject strobe", vcnt - base, 0);
        chk({op, dreg, wiper} == {p_op, p_dr, p_wp}, "R5 fields held",
            {op, dreg, wiper}, {p_op, p_dr, p_wp});
      end
    end

    // R2: clocks while deselected do not shift in
    strap = 2'b00;
    wclk(8);
    send_bits(8'hFF, 8);
    base = vcnt;
    frame(8'h50, 8'h96, 8'h00, 2);
    expect_cmd(base, 8'h96, "R2 deselected clocks");

    // R11: trailing byte ignored
    base = vcnt;
    frame(8'h50, 8'h25, 8'hFF, 3);
    expect_cmd(base, 8'h25, "R11 trailing byte");

    // R7: pause dropped mid command byte
    base = vcnt;
    sel_on();
    send_bits(8'h50, 8);
    send_bits(8'h74, 4);
    pause_n = 1'b0; wclk(6); pause_n = 1'b1;
    send_bits(8'h40, 4);
    sel_off();
    chk(vcnt == base, "R7 pause abort", vcnt - base, 0);

    // R7: write-protect dropped mid identification byte
    sel_on();
    send_bits(8'h50, 3);
    wp_n = 1'b0; wclk(6); wp_n = 1'b1;
    send_bits(8'h80, 5);
    send_bits(8'h33, 8);
    sel_off();
    chk(vcnt == base, "R7 wrprot abort", vcnt - base, 0);
    frame(8'h50, 8'h33, 8'h00, 2);
    expect_cmd(base, 8'h33, "R7 recovery");

    // R8: partial frame then clean frame
    base = vcnt;
    sel_on();
    send_bits(8'h50, 8);
    send_bits(8'hEE, 3);
    sel_off();
    chk(vcnt == base, "R8 partial frame", vcnt - base, 0);
    frame(8'h50, 8'h6B, 8'h00, 2);
    expect_cmd(base, 8'h6B, "R8 realign");

    // R9: deselect together with last command edge
    base = vcnt;
    p_op = op; p_dr = dreg; p_wp = wiper;
    sel_on();
    send_bits(8'h50, 8);
    send_bits(8'hC9, 7);
    mosi = 1'b1;
    wclk(8);
    sck = 1'b1;
    sel_n = 1'b1;
    wclk(8);
    sck = 1'b0;
    wclk(16);
    chk(vcnt == base, "R9 coincident deselect", vcnt - base, 0);
    chk({op, dreg, wiper} == {p_op, p_dr, p_wp}, "R9 fields held",
        {op, dreg, wiper}, {p_op, p_dr, p_wp});

    // R10: output never enabled
    chk(oe_seen == 0, "R10 miso enable over run", oe_seen, 0);
    chk({miso, miso_oe} == 2'b00, "R10 miso at end", {miso, miso_oe}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule